// File: doc/BRIEF.md
# Serial Storage Link Transmit Sequencer

This block is the transmit half of a device-side link layer for a serial storage link. It accepts one frame of 32-bit payload words from an upstream valid/ready/last stream. It sends those words to a PHY stream as 32-bit dwords, each with a 4-bit per-byte control-character flag. While it sends, it watches the primitive most recently received from the peer. Before the frame it runs a ready handshake with the peer. It stalls whenever the peer asks it to pause. It closes the frame with a CRC dword and an end marker. It then waits for the peer's final good or bad status before it goes back to idle fill.

Every payload dword and the CRC dword are whitened by XOR with a per-frame scrambler mask. The CRC is computed over the unscrambled payload. The scrambler and the CRC both restart at the start marker of each frame, so frames are independent of each other. Primitive dwords are never scrambled and carry a control flag on their low byte only.

Top module: `lnk_tx_seq`

## Requirements
- R1: Out of reset and whenever no frame is in flight, the block sends the idle primitive SYNC (0xB5B5957C) with `up_ready` low. Peer primitives received while idle have no effect on the output.
- R2: When `up_valid` is seen while idle, the block sends the ready-request primitive X_RDY (0x5757B57C) from the next cycle. It repeats X_RDY every cycle until `peer_prim` equals R_RDY (0x4A4A957C). Any other peer primitive, HOLD included, leaves it sending X_RDY.
- R3: In the cycle after R_RDY is received, the block sends exactly one start primitive SOF (0x3737B57C). It then enters the data phase.
- R4: In the data phase, including the CRC dword slot, each cycle in which `peer_prim` equals HOLD (0xD5D5AA7C) sends HOLDA (0x9595AA7C). In such a cycle `up_ready` is low, no word is consumed, and neither the scrambler nor the CRC advances.
- R5: A consumed payload word is sent as `up_data` XOR the current mask. Mask k of a frame (k = 0 at the first scrambled dword) takes 32 successive output bits, bit 0 first, of a 16-bit Fibonacci LFSR (x^16+x^15+x^13+x^4+1). The output bit is state bit 15. The state shifts left, taking in the XOR of state bits 15, 14, 12 and 3. The state is seeded with 0xF0F6 at SOF.
- R6: After the word flagged `up_last`, the next data slot carries the CRC dword XOR the next mask. The CRC is CRC-32 with polynomial 0x04C11DB7 and seed 0x52325032. It is computed MSB-first over each payload word (bit 31 first), with no reflection and no final XOR.
- R7: After the CRC dword the block sends one EOF (0xD5D5B57C). It then sends WTRM (0x5858B57C) every cycle until a status primitive arrives.
- R8: While the block sends WTRM, receiving R_OK (0x3535B57C) or R_ERR (0x5656B57C) pulses `stat_done` for that cycle. In the same cycle `stat_err` is 1 for R_ERR and 0 for R_OK. SYNC is sent from the next cycle.
- R9: `phy_ctrl` is 4'b0001 (low byte is a control character) for every primitive and 4'b0000 for every payload or CRC dword.
- R10: In the data phase, a cycle without HOLD and without `up_valid` sends HOLD (0xD5D5AA7C). It consumes nothing and leaves the scrambler and CRC unchanged.
- R11: `up_ready` is high exactly in data-phase cycles, before the CRC slot, in which the peer primitive is not HOLD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| up_valid | input | 1 | Upstream payload word valid |
| up_ready | output | 1 | Upstream payload word accepted this cycle when valid |
| up_data | input | 32 | Upstream payload word |
| up_last | input | 1 | Marks the final payload word of the frame |
| peer_prim | input | 32 | Primitive currently received from the peer |
| phy_data | output | 32 | Dword sent to the PHY stream |
| phy_ctrl | output | 4 | Per-byte control-character flags of `phy_data` |
| stat_done | output | 1 | One-cycle pulse when the frame status arrives |
| stat_err | output | 1 | Status was an error; valid with `stat_done` |

## Verification
Frames of random length from one to sixteen words are sent with random peer pause density and random upstream gaps. Matching every scrambled dword against the bench's own mask and CRC separates correct pointer handling from designs that advance the scrambler or CRC while paused or starved. The handshake and status waits are stretched by varied lengths and salted with HOLD and stray status primitives. This shows that only R_RDY opens a frame and only R_OK or R_ERR closes one. Directed cases cover single-word frames, a pause over the CRC slot, back-to-back frames that must restart the mask sequence, and status primitives arriving while idle.

// File: rtl/lnk_tx_pkg.sv
package lnk_tx_pkg;

    localparam int DWORD_W = 32;
    localparam int SCR_W   = 16;
    localparam int BYTES   = DWORD_W / 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_XRDY,
        ST_SOF,
        ST_DATA,
        ST_CRC,
        ST_EOF,
        ST_WTRM
    } tx_state_e;

    typedef struct packed {
        tx_state_e            st;
        logic [DWORD_W-1:0]   crc;
        logic [SCR_W-1:0]     lfsr;
    } tx_regs_t;

endpackage

// File: rtl/lnk_tx_crc_step.sv
module lnk_tx_crc_step #(
    parameter int              W    = 32,
    parameter logic [W-1:0]    POLY = 32'h04C11DB7
) (
    input  logic [W-1:0] crc_i,
    input  logic [W-1:0] data_i,
    output logic [W-1:0] crc_o
);
    logic [W-1:0] acc;
    logic         fb;

    always_comb begin
        acc = crc_i;
        fb  = 1'b0;
        for (int b = W - 1; b >= 0; b--) begin
            fb  = acc[W-1] ^ data_i[b];
            acc = {acc[W-2:0], 1'b0};
            if (fb) begin
                acc = acc ^ POLY;
            end
        end
        crc_o = acc;
    end
endmodule

// File: rtl/lnk_tx_scr_step.sv
module lnk_tx_scr_step #(
    parameter int              SW   = 16,
    parameter int              OW   = 32,
    parameter logic [SW-1:0]   TAPS = 16'hD008
) (
    input  logic [SW-1:0] st_i,
    output logic [OW-1:0] mask_o,
    output logic [SW-1:0] st_o
);
    logic [SW-1:0] s;
    logic [OW-1:0] m;

    always_comb begin
        s = st_i;
        m = '0;
        for (int i = 0; i < OW; i++) begin
            m[i] = s[SW-1];
            s    = {s[SW-2:0], ^(s & TAPS)};
        end
        mask_o = m;
        st_o   = s;
    end
endmodule

// File: rtl/lnk_tx_seq.sv
module lnk_tx_seq
    import lnk_tx_pkg::*;
#(
    parameter logic [31:0] P_SYNC    = 32'hB5B5957C,
    parameter logic [31:0] P_XRDY    = 32'h5757B57C,
    parameter logic [31:0] P_RRDY    = 32'h4A4A957C,
    parameter logic [31:0] P_SOF     = 32'h3737B57C,
    parameter logic [31:0] P_EOF     = 32'hD5D5B57C,
    parameter logic [31:0] P_WTRM    = 32'h5858B57C,
    parameter logic [31:0] P_HOLD    = 32'hD5D5AA7C,
    parameter logic [31:0] P_HOLDA   = 32'h9595AA7C,
    parameter logic [31:0] P_ROK     = 32'h3535B57C,
    parameter logic [31:0] P_RERR    = 32'h5656B57C,
    parameter logic [31:0] CRC_POLY  = 32'h04C11DB7,
    parameter logic [31:0] CRC_SEED  = 32'h52325032,
    parameter logic [15:0] SCR_SEED  = 16'hF0F6,
    parameter logic [15:0] SCR_TAPS  = 16'hD008
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        up_valid,
    output logic        up_ready,
    input  logic [31:0] up_data,
    input  logic        up_last,
    input  logic [31:0] peer_prim,
    output logic [31:0] phy_data,
    output logic [3:0]  phy_ctrl,
    output logic        stat_done,
    output logic        stat_err
);
    localparam logic [BYTES-1:0] CTRL_PRIM = BYTES'(1);
    localparam logic [BYTES-1:0] CTRL_DATA = '0;

    tx_regs_t r_d, r_q;

    logic [DWORD_W-1:0] crc_nx;
    logic [DWORD_W-1:0] mask;
    logic [SCR_W-1:0]   lfsr_nx;
    logic               peer_hold;
    logic               peer_stat;

    lnk_tx_crc_step #(.W(DWORD_W), .POLY(CRC_POLY)) u_crc (
        .crc_i  (r_q.crc),
        .data_i (up_data),
        .crc_o  (crc_nx)
    );

    lnk_tx_scr_step #(.SW(SCR_W), .OW(DWORD_W), .TAPS(SCR_TAPS)) u_scr (
        .st_i   (r_q.lfsr),
        .mask_o (mask),
        .st_o   (lfsr_nx)
    );

    assign peer_hold = (peer_prim == P_HOLD);
    assign peer_stat = (peer_prim == P_ROK) || (peer_prim == P_RERR);

    always_comb begin
        r_d       = r_q;
        up_ready  = 1'b0;
        phy_data  = P_SYNC;
        phy_ctrl  = CTRL_PRIM;
        stat_done = 1'b0;
        stat_err  = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (up_valid) begin
                    r_d.st = ST_XRDY;
                end
            end
            ST_XRDY: begin
                phy_data = P_XRDY;
                if (peer_prim == P_RRDY) begin
                    r_d.st = ST_SOF;
                end
            end
            ST_SOF: begin
                phy_data = P_SOF;
                r_d.st   = ST_DATA;
                r_d.crc  = CRC_SEED;
                r_d.lfsr = SCR_SEED;
            end
            ST_DATA: begin
                if (peer_hold) begin
                    phy_data = P_HOLDA;
                end else begin
                    up_ready = 1'b1;
                    if (up_valid) begin
                        phy_data = up_data ^ mask;
                        phy_ctrl = CTRL_DATA;
                        r_d.crc  = crc_nx;
                        r_d.lfsr = lfsr_nx;
                        if (up_last) begin
                            r_d.st = ST_CRC;
                        end
                    end else begin
                        phy_data = P_HOLD;
                    end
                end
            end
            ST_CRC: begin
                if (peer_hold) begin
                    phy_data = P_HOLDA;
                end else begin
                    phy_data = r_q.crc ^ mask;
                    phy_ctrl = CTRL_DATA;
                    r_d.lfsr = lfsr_nx;
                    r_d.st   = ST_EOF;
                end
            end
            ST_EOF: begin
                phy_data = P_EOF;
                r_d.st   = ST_WTRM;
            end
            ST_WTRM: begin
                phy_data = P_WTRM;
                if (peer_stat) begin
                    stat_done = 1'b1;
                    stat_err  = (peer_prim == P_RERR);
                    r_d.st    = ST_IDLE;
                end
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st   <= ST_IDLE;
            r_q.crc  <= CRC_SEED;
            r_q.lfsr <= SCR_SEED;
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/lnk_tx_seq_chk.sv
module lnk_tx_seq_chk #(
    parameter logic [31:0] P_SYNC  = 32'hB5B5957C,
    parameter logic [31:0] P_XRDY  = 32'h5757B57C,
    parameter logic [31:0] P_RRDY  = 32'h4A4A957C,
    parameter logic [31:0] P_SOF   = 32'h3737B57C,
    parameter logic [31:0] P_EOF   = 32'hD5D5B57C,
    parameter logic [31:0] P_WTRM  = 32'h5858B57C,
    parameter logic [31:0] P_HOLD  = 32'hD5D5AA7C,
    parameter logic [31:0] P_HOLDA = 32'h9595AA7C
) (
    input logic        clk,
    input logic        rst_n,
    input logic        up_ready,
    input logic [31:0] peer_prim,
    input logic [31:0] phy_data,
    input logic [3:0]  phy_ctrl,
    input logic        stat_done,
    input logic        stat_err
);
    logic is_prim;
    assign is_prim = (phy_ctrl == 4'b0001);

    p_ctrl_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_ctrl == 4'b0000) || (phy_ctrl == 4'b0001));

    p_xrdy_repeat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (is_prim && phy_data == P_XRDY && peer_prim != P_RRDY)
        |=> (is_prim && phy_data == P_XRDY));

    p_sof_after_rrdy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (is_prim && phy_data == P_XRDY && peer_prim == P_RRDY)
        |=> (is_prim && phy_data == P_SOF));

    p_sof_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (is_prim && phy_data == P_SOF) |=> !(is_prim && phy_data == P_SOF));

    p_hold_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (is_prim && phy_data == P_HOLDA) |-> !up_ready);

    p_eof_then_wtrm_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (is_prim && phy_data == P_EOF) |=> (is_prim && phy_data == P_WTRM));

    p_done_in_wtrm_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stat_done |-> (is_prim && phy_data == P_WTRM));

    p_done_then_sync_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stat_done |=> (is_prim && phy_data == P_SYNC));

    p_err_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stat_err |-> stat_done);

    p_ready_no_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        up_ready |-> (peer_prim != P_HOLD));
endmodule

bind lnk_tx_seq lnk_tx_seq_chk #(
    .P_SYNC  (P_SYNC),
    .P_XRDY  (P_XRDY),
    .P_RRDY  (P_RRDY),
    .P_SOF   (P_SOF),
    .P_EOF   (P_EOF),
    .P_WTRM  (P_WTRM),
    .P_HOLD  (P_HOLD),
    .P_HOLDA (P_HOLDA)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .up_ready  (up_ready),
    .peer_prim (peer_prim),
    .phy_data  (phy_data),
    .phy_ctrl  (phy_ctrl),
    .stat_done (stat_done),
    .stat_err  (stat_err)
);

// File: tb/lnk_tx_seq_test.sv
`timescale 1ns/1ps
module lnk_tx_seq_test;
    localparam logic [31:0] P_SYNC  = 32'hB5B5957C;
    localparam logic [31:0] P_XRDY  = 32'h5757B57C;
    localparam logic [31:0] P_RRDY  = 32'h4A4A957C;
    localparam logic [31:0] P_SOF   = 32'h3737B57C;
    localparam logic [31:0] P_EOF   = 32'hD5D5B57C;
    localparam logic [31:0] P_WTRM  = 32'h5858B57C;
    localparam logic [31:0] P_HOLD  = 32'hD5D5AA7C;
    localparam logic [31:0] P_HOLDA = 32'h9595AA7C;
    localparam logic [31:0] P_ROK   = 32'h3535B57C;
    localparam logic [31:0] P_RERR  = 32'h5656B57C;
    localparam logic [31:0] P_FILL  = 32'h5555B57C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        up_valid = 1'b0;
    logic        up_ready;
    logic [31:0] up_data = '0;
    logic        up_last = 1'b0;
    logic [31:0] peer_prim = P_SYNC;
    logic [31:0] phy_data;
    logic [3:0]  phy_ctrl;
    logic        stat_done;
    logic        stat_err;

    int n_chk = 0;
    int n_err = 0;
    logic [31:0] pay [16];

    always #2.5 clk = ~clk;

    lnk_tx_seq uut (
        .clk(clk), .rst_n(rst_n), .up_valid(up_valid), .up_ready(up_ready),
        .up_data(up_data), .up_last(up_last), .peer_prim(peer_prim),
        .phy_data(phy_data), .phy_ctrl(phy_ctrl),
        .stat_done(stat_done), .stat_err(stat_err)
    );

    function automatic logic [31:0] f_mask(logic [15:0] s);
        logic [31:0] m;
        for (int k = 0; k < 32; k++) begin
            m[k] = s[15];
            s = {s[14:0], s[15] ^ s[14] ^ s[12] ^ s[3]};
        end
        return m;
    endfunction

    function automatic logic [15:0] f_adv(logic [15:0] s);
        for (int k = 0; k < 32; k++) s = {s[14:0], s[15] ^ s[14] ^ s[12] ^ s[3]};
        return s;
    endfunction

    function automatic logic [31:0] f_crc(logic [31:0] c, logic [31:0] d);
        logic fb;
        for (int b = 31; b >= 0; b--) begin
            fb = c[31] ^ d[b];
            c = {c[30:0], 1'b0};
            if (fb) c = c ^ 32'h04C11DB7;
        end
        return c;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%08h expected=%08h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic expect_out(input string tag, input logic [31:0] d, input logic [3:0] c,
                              input bit rdy, input bit dn, input bit er);
        chk(phy_data == d, tag, phy_data, d);
        chk(phy_ctrl == c, {tag, " R9 ctrl"}, 32'(phy_ctrl), 32'(c));
        chk(up_ready == rdy, {tag, " R11 ready"}, 32'(up_ready), 32'(rdy));
        chk(stat_done == dn, {tag, " R8 done"}, 32'(stat_done), 32'(dn));
        chk(stat_err == er, {tag, " R8 err"}, 32'(stat_err), 32'(er));
    endtask

    task automatic idle_cycle(input logic [31:0] peer);
        @(negedge clk);
        up_valid = 1'b0; up_last = 1'b0; peer_prim = peer;
        #1 expect_out("R1 idle", P_SYNC, 4'b0001, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic run_frame(input int len, input int hold_pct, input int gap_pct,
                             input bit want_err, input int xrdy_wait, input int wtrm_wait,
                             input bit hold_crc);
        int ph = 0;
        int wc = 0;
        int idx = 0;
        int guard = 0;
        bit hold, v, fin;
        logic [15:0] ls = 16'h0;
        logic [31:0] cs = 32'h0;
        for (int i = 0; i < len; i++) pay[i] = $urandom;
        fin = 1'b0;
        while (!fin && guard < 2000) begin
            guard++;
            @(negedge clk);
            hold = 1'b0; v = 1'b0;
            case (ph)
                0: begin peer_prim = P_SYNC; up_valid = 1'b1; up_data = pay[0]; up_last = (len == 1); end
                1: begin
                    peer_prim = (wc >= xrdy_wait) ? P_RRDY : ((wc % 2) ? P_HOLD : P_ROK);
                    wc++;
                end
                2: peer_prim = P_FILL;
                3: begin
                    hold = ($urandom % 100) < hold_pct;
                    v = ($urandom % 100) >= gap_pct;
                    peer_prim = hold ? P_HOLD : P_FILL;
                    up_valid = v; up_data = pay[idx]; up_last = (idx == len - 1);
                end
                4: begin
                    hold = hold_crc ? (wc < 3) : (($urandom % 100) < hold_pct);
                    wc++;
                    peer_prim = hold ? P_HOLD : P_FILL;
                    up_valid = 1'b0; up_last = 1'b0;
                end
                5: peer_prim = P_FILL;
                default: begin
                    peer_prim = (wc >= wtrm_wait) ? (want_err ? P_RERR : P_ROK)
                                                  : ((wc % 2) ? P_HOLD : P_FILL);
                    wc++;
                end
            endcase
            #1;
            case (ph)
                0: begin expect_out("R1 sync before request", P_SYNC, 4'b0001, 0, 0, 0); ph = 1; wc = 0; end
                1: begin
                    expect_out("R2 xrdy", P_XRDY, 4'b0001, 0, 0, 0);
                    if (peer_prim == P_RRDY) ph = 2;
                end
                2: begin
                    expect_out("R3 sof", P_SOF, 4'b0001, 0, 0, 0);
                    ph = 3; ls = 16'hF0F6; cs = 32'h52325032; idx = 0;
                end
                3: begin
                    if (hold) expect_out("R4 holda in data", P_HOLDA, 4'b0001, 0, 0, 0);
                    else if (!v) expect_out("R10 starved hold", P_HOLD, 4'b0001, 1, 0, 0);
                    else begin
                        expect_out("R5 scrambled payload", pay[idx] ^ f_mask(ls), 4'b0000, 1, 0, 0);
                        cs = f_crc(cs, pay[idx]); ls = f_adv(ls);
                        if (idx == len - 1) begin ph = 4; wc = 0; end
                        idx++;
                    end
                end
                4: begin
                    if (hold) expect_out("R4 holda in crc slot", P_HOLDA, 4'b0001, 0, 0, 0);
                    else begin
                        expect_out("R6 scrambled crc", cs ^ f_mask(ls), 4'b0000, 0, 0, 0);
                        ls = f_adv(ls); ph = 5;
                    end
                end
                5: begin expect_out("R7 eof", P_EOF, 4'b0001, 0, 0, 0); ph = 6; wc = 0; end
                default: begin
                    if (peer_prim == P_ROK || peer_prim == P_RERR) begin
                        expect_out("R8 status", P_WTRM, 4'b0001, 0, 1, want_err);
                        fin = 1'b1;
                    end else begin
                        expect_out("R7 wtrm", P_WTRM, 4'b0001, 0, 0, 0);
                    end
                end
            endcase
        end
        chk(fin, "R8 frame completion", 32'(fin), 32'd1);
        idle_cycle(P_FILL);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        #1;
        expect_out("R1 reset", P_SYNC, 4'b0001, 0, 0, 0);
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        idle_cycle(P_ROK);
        idle_cycle(P_RRDY);
        idle_cycle(P_HOLD);
        idle_cycle(P_RERR);
        run_frame(1, 0, 0, 1'b0, 0, 0, 1'b0);
        run_frame(1, 0, 0, 1'b1, 3, 4, 1'b1);
        run_frame(4, 0, 0, 1'b0, 1, 1, 1'b0);
        run_frame(4, 0, 0, 1'b0, 1, 1, 1'b0);
        run_frame(16, 40, 30, 1'b1, 5, 2, 1'b1);
        for (int f = 0; f < 40; f++) begin
            run_frame(1 + ($urandom % 16), $urandom % 50, $urandom % 40,
                      ($urandom % 2) == 1, $urandom % 6, $urandom % 6, ($urandom % 4) == 0);
        end
        idle_cycle(P_ROK);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule